// File: doc/BRIEF.md
# I2C Master Transmit Engine with Flag Handshake

This block drives an I2C bus as a master that only sends. A host works it through four byte-wide registers: a control register with start and stop requests and an interrupt flag, a data register, a read-only status register and a clock divider. The engine moves the bus one protocol step at a time. Each step is a START, a repeated START, or one byte plus its acknowledge slot. At the end of each step the engine raises the interrupt flag, posts a status code, and parks with SCL pulled low. It does nothing more until the host clears the flag.

SCL and SDA are open-drain. For each line the block has an output enable, which pulls the line low, and an input that reads the line level. The clock divider sets SCL timing. A slave may stretch the clock by holding SCL low, and the engine waits until the line is actually high before it times the high phase.

Top module: `i2c_txm`

## Requirements
- R1: After reset the flag and `irq` are 0, the status register (address 2) reads F8h, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: Writing 1 to control bit 5 (address 0) requests a START. The engine waits while the bus is busy, meaning a START has been seen and no STOP since. It then pulls SDA low while SCL is high, sets the flag, and the status reads 08h.
- R3: Whenever the flag is set, SCL is held low on the bus.
- R4: While the flag is set the bus does not advance, and writing the data register does not restart it. The only trigger to continue is a control write with bit 3 equal to 0, which clears the flag. Control bit 3 reads back the flag.
- R5: A byte step sends the data register on SDA, most significant bit first, as 8 bits. SDA is released for the ninth clock, and its level at the end of that clock's high phase is taken as the acknowledge (low means ACK). The first byte after any START reports 18h for ACK or 20h for NACK. Later bytes report 28h for ACK or 30h for NACK.
- R6: If control bit 5 is set when the flag is cleared, the engine issues a repeated START and reports status 10h.
- R7: If control bit 4 is set when the flag is cleared, the engine issues a STOP (SDA rises while SCL is high) and releases both lines. It then returns to idle without setting the flag, and the bus counts as free for a new START.
- R8: SDA changes while SCL is high only for START and STOP conditions, never inside a byte.
- R9: After SCL is released, the engine waits while a slave holds SCL low. Each bit's high phase lasts between divider+1 and divider+2 clock cycles after SCL is first seen high.
- R10: Without stretching, the SCL low phase between consecutive bits of a byte lasts divider+1 clock cycles. The divider is register address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status, 3 divider |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the register at reg_addr |
| irq | output | 1 | Interrupt flag |
| scl_in | input | 1 | Level of the SCL line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_in | input | 1 | Level of the SDA line |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A bad sequencing state shows up at the ports within one bit time: a wrong byte seen by the slave, a START or STOP inside a byte, or a flag raised while SCL is high. A wrong acknowledge or first-byte record shows up in the status code at the next flag. A timing-counter fault shows up as a high or low phase of the wrong length on the very next SCL edge. A busy-tracking fault either lets a START go out over another master's traffic within a few cycles, or blocks the START after a STOP until the watchdog expires.

// File: rtl/i2c_txm.sv
module i2c_txm #(
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(4)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe
);
  localparam int BITS = 8;
  localparam int BC_W = $clog2(BITS + 1);
  localparam logic [1:0] A_CTL = 2'd0, A_DAT = 2'd1, A_STAT = 2'd2, A_DIV = 2'd3;
  localparam int B_STA = 5, B_STO = 4, B_FLG = 3;

  typedef enum logic [2:0] {S_IDLE, S_EDGE, S_HOLD, S_LOW, S_RISE, S_HIGH} st_t;
  typedef enum logic [1:0] {OP_START, OP_RSTART, OP_BIT, OP_STOP} op_t;

  st_t st;
  op_t op;
  logic [DIV_W-1:0] cnt, div_q;
  logic [7:0] data_q, shreg, status;
  logic [BC_W-1:0] bitcnt;
  logic flag, sta_req, sto_req, sda_oe_q, addr_phase, busy, scl_d, sda_d;

  wire cnt_done = (cnt == div_q);
  wire last_bit = (bitcnt == BC_W'(BITS));
  wire start_det = scl_d && scl_in && sda_d && !sda_in;
  wire stop_det  = scl_d && scl_in && !sda_d && sda_in;
  wire sda_next  = (op == OP_BIT) ? (!last_bit && !shreg[7]) : (op == OP_STOP);

  assign scl_oe = (st == S_HOLD) || (st == S_LOW);
  assign sda_oe = sda_oe_q;
  assign irq = flag;

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {2'b00, sta_req, sto_req, flag, 3'b000};
      A_DAT:   reg_rdata = data_q;
      A_STAT:  reg_rdata = status;
      default: reg_rdata = 8'(div_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_START; cnt <= '0; div_q <= DIV_RESET;
      data_q <= '0; shreg <= '0; status <= 8'hF8; bitcnt <= '0;
      flag <= 1'b0; sta_req <= 1'b0; sto_req <= 1'b0; sda_oe_q <= 1'b0;
      addr_phase <= 1'b0; busy <= 1'b0; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
      if (start_det) busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;

      if (reg_we) begin
        case (reg_addr)
          A_CTL: begin
            if (reg_wdata[B_STA]) sta_req <= 1'b1;
            if (reg_wdata[B_STO]) sto_req <= 1'b1;
            if (!reg_wdata[B_FLG]) flag <= 1'b0;
          end
          A_DAT:   data_q <= reg_wdata;
          A_DIV:   div_q <= DIV_W'(reg_wdata);
          default: ;
        endcase
      end

      case (st)
        S_IDLE: begin
          cnt <= '0;
          sto_req <= 1'b0;
          if (sta_req && !busy) begin
            st <= S_EDGE;
            op <= OP_START;
            sda_oe_q <= 1'b1;
          end
        end
        S_EDGE: begin
          cnt <= cnt + 1'b1;
          if (cnt_done) begin
            cnt <= '0;
            if (op == OP_STOP) begin
              st <= S_IDLE;
              sto_req <= 1'b0;
            end else begin
              st <= S_HOLD;
              flag <= 1'b1;
              status <= (op == OP_START) ? 8'h08 : 8'h10;
              sta_req <= 1'b0;
              addr_phase <= 1'b1;
            end
          end
        end
        S_HOLD: begin
          if (!flag) begin
            cnt <= '0;
            bitcnt <= '0;
            st <= S_LOW;
            if (sto_req) op <= OP_STOP;
            else if (sta_req) op <= OP_RSTART;
            else begin
              op <= OP_BIT;
              shreg <= data_q;
            end
          end
        end
        S_LOW: begin
          if (cnt == '0) sda_oe_q <= sda_next;
          cnt <= cnt + 1'b1;
          if (cnt_done) begin
            cnt <= '0;
            st <= S_RISE;
          end
        end
        S_RISE: begin
          if (scl_in) st <= S_HIGH;
        end
        S_HIGH: begin
          cnt <= cnt + 1'b1;
          if (cnt_done) begin
            cnt <= '0;
            case (op)
              OP_BIT: begin
                if (last_bit) begin
                  flag <= 1'b1;
                  status <= addr_phase ? (sda_in ? 8'h20 : 8'h18)
                                       : (sda_in ? 8'h30 : 8'h28);
                  addr_phase <= 1'b0;
                  st <= S_HOLD;
                end else begin
                  bitcnt <= bitcnt + 1'b1;
                  shreg <= {shreg[6:0], 1'b0};
                  st <= S_LOW;
                end
              end
              OP_RSTART: begin
                sda_oe_q <= 1'b1;
                st <= S_EDGE;
              end
              OP_STOP: begin
                sda_oe_q <= 1'b0;
                st <= S_EDGE;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> scl_oe);

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && $past(flag)) |-> ($stable(sda_oe_q) && $stable(st)));

  assert_status_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (status == 8'h08 || status == 8'h10 || status == 8'h18 ||
                     status == 8'h20 || status == 8'h28 || status == 8'h30));

  assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sto_req) |-> (!flag && !scl_oe));

  assert_sda_low_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_q) && !scl_oe) |-> (st == S_EDGE));

  assert_high_after_seen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && $past(st) == S_RISE) |-> $past(scl_in));
endmodule

// File: tb/i2c_txm_tb_top.sv
module i2c_txm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_scl_low = 1'b0;
  logic slv_sda_low = 1'b0;
  wire scl_in = !(scl_oe || slv_scl_low);
  wire sda_in = !(sda_oe || slv_sda_low);

  i2c_txm dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_in), .scl_oe(scl_oe), .sda_in(sda_in), .sda_oe(sda_oe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave / bus monitor model
  bit ack_en = 1'b1;
  int stretch_n = 0;
  int stretch_left = 0;
  int stretch_seen = 0;
  int n_start = 0, n_stop = 0;
  int bcnt = 0, high_len = 0, low_len = 0;
  bit ev_in_high = 1'b0, low_chk = 1'b0;
  bit prev_scl = 1'b1, prev_sda = 1'b1;
  logic [8:0] shf = '0;
  logic [7:0] bytes_q[$];
  bit acks_q[$];

  always @(negedge clk) begin
    bit cs, cd;
    cs = scl_in;
    cd = sda_in;
    if (rst_n && irq) chk(!cs, "R3 SCL low while flag set", int'(cs), 0);
    if (prev_scl && cs && prev_sda && !cd) begin
      n_start++;
      chk(bcnt <= 1, "R8 START only outside a byte", bcnt, 0);
      bcnt = 0;
      ev_in_high = 1'b1;
    end
    if (prev_scl && cs && !prev_sda && cd) begin
      n_stop++;
      chk(bcnt <= 1, "R8 STOP only outside a byte", bcnt, 0);
      bcnt = 0;
      ev_in_high = 1'b1;
    end
    if (!prev_scl && cs) begin
      if (low_chk && stretch_n == 0)
        chk(low_len == DIV + 1, "R10 low phase length", low_len, DIV + 1);
      low_chk = 1'b0;
      bcnt++;
      shf = {shf[7:0], cd};
      high_len = 1;
      ev_in_high = 1'b0;
    end else if (cs) begin
      high_len++;
    end
    if (prev_scl && !cs) begin
      if (!ev_in_high && bcnt > 0)
        chk(high_len >= DIV + 1 && high_len <= DIV + 2, "R9 high phase length", high_len, DIV + 1);
      low_chk = (bcnt >= 1 && bcnt <= 8);
      if (bcnt == 8) begin
        bytes_q.push_back(shf[7:0]);
        if (ack_en) slv_sda_low = 1'b1;
      end
      if (bcnt == 9) begin
        acks_q.push_back(shf[0]);
        slv_sda_low = 1'b0;
        bcnt = 0;
      end
      low_len = 1;
      if (stretch_n > 0) begin
        stretch_left = stretch_n;
        slv_scl_low = 1'b1;
      end
    end else if (!cs) begin
      low_len++;
      if (!scl_oe && slv_scl_low) stretch_seen++;
      if (stretch_left > 0) begin
        stretch_left--;
        if (stretch_left == 0) slv_scl_low = 1'b0;
      end
    end
    prev_scl = scl_in;
    prev_sda = sda_in;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(irq == 1'b1, req, int'(irq), 1);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit ack, input logic [7:0] exp_st, input string req);
    logic [7:0] v;
    logic [7:0] got;
    bit a;
    ack_en = ack;
    wr(2'd1, d);
    wr(2'd0, 8'h00);
    wait_irq(req);
    rd(2'd2, v);
    chk(v == exp_st, req, int'(v), int'(exp_st));
    got = (bytes_q.size() > 0) ? bytes_q.pop_front() : 8'hxx;
    chk(got === d, "R5 byte on bus MSB first", int'(got), int'(d));
    a = (acks_q.size() > 0) ? acks_q.pop_front() : 1'b0;
    chk(a == !ack, "R5 acknowledge slot level", int'(a), int'(!ack));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired (run hung)");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int ns, np, nb;
    repeat (5) @(negedge clk);
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", int'({scl_oe, sda_oe}), 0);
    rd(2'd2, v);
    chk(v == 8'hF8, "R1 status after reset", int'(v), 8'hF8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    wr(2'd3, 8'(DIV));
    rd(2'd3, v);
    chk(v == 8'(DIV), "R10 divider readback", int'(v), DIV);

    // another master owns the bus
    slv_sda_low = 1'b1;
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h20);
    repeat (40) @(negedge clk);
    chk(irq == 1'b0 && sda_oe == 1'b0, "R2 start waits on busy bus", int'({irq, sda_oe}), 0);
    slv_sda_low = 1'b0;
    wait_irq("R2 flag after START");
    rd(2'd2, v);
    chk(v == 8'h08, "R2 status after START", int'(v), 8'h08);
    chk(n_start == 2, "R2 START on bus", n_start, 2);
    rd(2'd0, v);
    chk(v == 8'h08, "R4 control shows flag, start bit cleared", int'(v), 8'h08);

    // stall while flag set, data write alone does nothing
    nb = bytes_q.size();
    wr(2'd1, 8'hA4);
    repeat (30) @(negedge clk);
    chk(irq == 1'b1 && scl_oe == 1'b1, "R4 stalled while flag set", int'({irq, scl_oe}), 3);
    chk(bytes_q.size() == nb && bcnt == 0, "R4 no bus activity while flag set", bcnt, 0);

    send_byte(8'hA4, 1'b1, 8'h18, "R5 address ACK status");
    send_byte(8'h3C, 1'b1, 8'h28, "R5 data ACK status");
    send_byte(8'h81, 1'b0, 8'h30, "R5 data NACK status");

    ns = n_start;
    wr(2'd0, 8'h20);
    wait_irq("R6 flag after repeated START");
    rd(2'd2, v);
    chk(v == 8'h10, "R6 status after repeated START", int'(v), 8'h10);
    chk(n_start == ns + 1, "R6 repeated START on bus", n_start, ns + 1);
    send_byte(8'hB0, 1'b0, 8'h20, "R5 address NACK status");

    wr(2'd0, 8'h20);
    wait_irq("R6 second repeated START");
    stretch_n = 6;
    send_byte(8'h52, 1'b1, 8'h18, "R9 address under stretching");
    send_byte(8'h5A, 1'b1, 8'h28, "R9 data under stretching");
    chk(stretch_seen > 0, "R9 stretching observed", stretch_seen, 1);
    stretch_n = 0;
    repeat (10) @(negedge clk);

    np = n_stop;
    wr(2'd0, 8'h10);
    repeat (60) @(negedge clk);
    chk(n_stop == np + 1, "R7 STOP on bus", n_stop, np + 1);
    chk(irq == 1'b0, "R7 no flag after STOP", int'(irq), 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R7 lines released", int'({scl_oe, sda_oe}), 0);

    wr(2'd0, 8'h20);
    wait_irq("R7 new START after STOP");
    rd(2'd2, v);
    chk(v == 8'h08, "R7 status for fresh START", int'(v), 8'h08);
    send_byte(8'hE6, 1'b1, 8'h18, "R5 address after fresh START");
    wr(2'd0, 8'h10);
    repeat (60) @(negedge clk);
    chk(n_stop == np + 2 && irq == 1'b0, "R7 final STOP", n_stop, np + 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule